// File: doc/BRIEF.md
# Message Frame Queue Port

This block places four circular queues of 32-bit message frame addresses behind two host-visible register addresses. A host read of a port register removes the oldest address from one queue. A host write to the same register appends the written address to a different queue. The inbound register at offset 0x040 reads from the inbound free queue and writes to the inbound posted queue. The outbound register at offset 0x044 pairs its queues the other way round: it reads from the outbound posted queue and writes to the outbound free queue.

The local processor side has two producer interfaces and two consumer interfaces, each with a valid/ready handshake. The producers refill the inbound free queue and fill the outbound posted queue. The consumers drain the inbound posted queue and the outbound free queue. The block reports per-queue empty and full flags and a sticky overflow flag. It also drives a level output that stays high while posted inbound work is waiting, which can serve as an interrupt to the local processor.

Host accesses are decoded by a small state machine whose state records the outcome of the previous cycle's access. The states are ST_IDLE (no access), ST_RD_OK (a pop returned data), ST_RD_EMPTY (a read found its source queue empty), ST_WR_OK (a push was accepted), ST_WR_DROP (a push was refused because the queue was full), ST_RD_UNMAPPED (a read of any other offset) and ST_WR_IGNORED (a write to any other offset). Every cycle moves the machine to the state named by that cycle's access. A cycle without a strobe returns it to ST_IDLE. The read response is valid in the three read states.

Top module: `mfq_port`

## Requirements
- R1: After reset, host_rdata is 0, host_rvalid is 0, q_empty is 4'b1111, q_full is 4'b0000, overflow is 0 and post_irq is 0.
- R2: A host read (host_sel=1, host_wr=0) of offset 0x040 pops the oldest entry of the inbound free queue. The value appears on host_rdata with host_rvalid=1 in the cycle after the strobe, and entries come out in the order they were pushed.
- R3: A host write of offset 0x040 pushes host_wdata onto the inbound posted queue. The local side reads it back, in order, through ip_pop_valid/ip_pop_data/ip_pop_ready.
- R4: A host read of offset 0x044 pops the oldest entry of the outbound posted queue, which is filled through op_push_valid/op_push_data/op_push_ready.
- R5: A host write of offset 0x044 pushes host_wdata onto the outbound free queue. The local side drains it through of_pop_valid/of_pop_data/of_pop_ready.
- R6: A host read whose source queue is empty returns 32'hFFFFFFFF with host_rvalid=1 and leaves that queue unchanged.
- R7: A host write whose destination queue is full is discarded. It sets overflow, which then stays 1 until reset.
- R8: Each queue holds 16 entries. q_empty and q_full use bit 0 for inbound free, bit 1 for inbound posted, bit 2 for outbound posted and bit 3 for outbound free. A local push ready is low while its queue is full.
- R9: post_irq is 1 exactly while the inbound posted queue holds at least one entry.
- R10: A host access to any offset other than 0x040 or 0x044 changes no queue. A read of such an offset returns 0 with host_rvalid=1.
- R11: A host operation and a local operation on the same queue in the same cycle both take effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| host_sel | input | 1 | Host access strobe, one cycle per access |
| host_wr | input | 1 | 1 = write, 0 = read |
| host_addr | input | 12 | Register byte offset |
| host_wdata | input | 32 | Host write data |
| host_rdata | output | 32 | Read data of the last host read |
| host_rvalid | output | 1 | Read response valid, one cycle after the read strobe |
| lf_push_valid | input | 1 | Local push request, inbound free queue |
| lf_push_data | input | 32 | Frame address to push, inbound free queue |
| lf_push_ready | output | 1 | Inbound free queue can accept |
| op_push_valid | input | 1 | Local push request, outbound posted queue |
| op_push_data | input | 32 | Frame address to push, outbound posted queue |
| op_push_ready | output | 1 | Outbound posted queue can accept |
| ip_pop_valid | output | 1 | Inbound posted queue has an entry |
| ip_pop_data | output | 32 | Oldest inbound posted entry |
| ip_pop_ready | input | 1 | Local side takes the inbound posted entry |
| of_pop_valid | output | 1 | Outbound free queue has an entry |
| of_pop_data | output | 32 | Oldest outbound free entry |
| of_pop_ready | input | 1 | Local side takes the outbound free entry |
| q_empty | output | 4 | Per-queue empty flags (order in R8) |
| q_full | output | 4 | Per-queue full flags (order in R8) |
| overflow | output | 1 | Sticky dropped-write flag |
| post_irq | output | 1 | Inbound posted queue not empty |

## Verification
The assertions check several properties on every cycle. No queue is pushed while full or popped while empty. Each count stays within the depth. Every read strobe is answered on the next cycle. An empty-queue read yields all ones. The overflow flag never falls outside reset, and no strobe to an unmapped offset moves a queue. Some behaviour can only be shown by the bench's scenarios: the first-in first-out order through each pairing of read and write queues, the crossed pairing between the two ports, the exact sixteen-entry boundary with the dropped seventeenth write, and same-cycle host and local traffic on one queue.

// File: rtl/mfq_pkg.sv
package mfq_pkg;

    // Queue indices; also the bit order of q_empty / q_full
    localparam int QI_IN_FREE  = 0;
    localparam int QI_IN_POST  = 1;
    localparam int QI_OUT_POST = 2;
    localparam int QI_OUT_FREE = 3;
    localparam int NUM_Q       = 4;

    // Outcome of the previous cycle's host access
    typedef enum logic [2:0] {
        ST_IDLE        = 3'd0,
        ST_RD_OK       = 3'd1,
        ST_RD_EMPTY    = 3'd2,
        ST_WR_OK       = 3'd3,
        ST_WR_DROP     = 3'd4,
        ST_RD_UNMAPPED = 3'd5,
        ST_WR_IGNORED  = 3'd6
    } host_state_e;

endpackage

// File: rtl/mfq_ring.sv
module mfq_ring #(
    parameter int DW    = 32,
    parameter int DEPTH = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          push,
    input  logic [DW-1:0] push_data,
    input  logic          pop,
    output logic [DW-1:0] head_data,
    output logic          empty,
    output logic          full
);
    localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CW = $clog2(DEPTH + 1);
    localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);

    logic [DW-1:0] mem [DEPTH];
    logic [AW-1:0] wr_ptr;
    logic [AW-1:0] rd_ptr;
    logic [CW-1:0] count;

    function automatic logic [AW-1:0] bump(input logic [AW-1:0] p);
        return (p == LAST) ? '0 : p + 1'b1;
    endfunction

    always_ff @(posedge clk) begin
        if (push) begin
            mem[wr_ptr] <= push_data;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
        end else begin
            if (push) begin
                wr_ptr <= bump(wr_ptr);
            end
            if (pop) begin
                rd_ptr <= bump(rd_ptr);
            end
            unique case ({push, pop})
                2'b10:   count <= count + 1'b1;
                2'b01:   count <= count - 1'b1;
                default: count <= count;
            endcase
        end
    end

    assign head_data = mem[rd_ptr];
    assign empty     = (count == '0);
    assign full      = (count == CW'(DEPTH));

    // R8: the qualifying logic upstream never pushes a full queue
    p_no_overflow_r8: assert property (@(posedge clk) disable iff (!rst_n)
        full |-> !push);

    // R6: never pops an empty queue
    p_no_underflow_r6: assert property (@(posedge clk) disable iff (!rst_n)
        empty |-> !pop);

    // R8: occupancy stays within the depth
    p_count_bound_r8: assert property (@(posedge clk) disable iff (!rst_n)
        count <= CW'(DEPTH));

endmodule

// File: rtl/mfq_host_ctl.sv
module mfq_host_ctl
    import mfq_pkg::*;
#(
    parameter int            DW      = 32,
    parameter int            AW      = 12,
    parameter logic [AW-1:0] IN_OFS  = 12'h040,
    parameter logic [AW-1:0] OUT_OFS = 12'h044
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          sel,
    input  logic          wr,
    input  logic [AW-1:0] addr,
    input  logic          in_free_empty,
    input  logic [DW-1:0] in_free_head,
    input  logic          in_post_full,
    input  logic          out_post_empty,
    input  logic [DW-1:0] out_post_head,
    input  logic          out_free_full,
    output logic          in_free_pop,
    output logic          in_post_push,
    output logic          out_post_pop,
    output logic          out_free_push,
    output logic [DW-1:0] rdata,
    output logic          rvalid,
    output logic          overflow
);
    host_state_e   state_q;
    host_state_e   state_d;
    logic [DW-1:0] rdata_d;
    logic          hit_in;
    logic          hit_out;

    assign hit_in  = (addr == IN_OFS);
    assign hit_out = (addr == OUT_OFS);

    // Next state, queue strobes and read data for this cycle's access
    always_comb begin
        state_d       = ST_IDLE;
        rdata_d       = rdata;
        in_free_pop   = 1'b0;
        in_post_push  = 1'b0;
        out_post_pop  = 1'b0;
        out_free_push = 1'b0;
        if (sel) begin
            if (hit_in) begin
                if (wr) begin
                    if (!in_post_full) begin
                        in_post_push = 1'b1;
                        state_d      = ST_WR_OK;
                    end else begin
                        state_d      = ST_WR_DROP;
                    end
                end else if (!in_free_empty) begin
                    in_free_pop = 1'b1;
                    rdata_d     = in_free_head;
                    state_d     = ST_RD_OK;
                end else begin
                    rdata_d     = '1;
                    state_d     = ST_RD_EMPTY;
                end
            end else if (hit_out) begin
                if (wr) begin
                    if (!out_free_full) begin
                        out_free_push = 1'b1;
                        state_d       = ST_WR_OK;
                    end else begin
                        state_d       = ST_WR_DROP;
                    end
                end else if (!out_post_empty) begin
                    out_post_pop = 1'b1;
                    rdata_d      = out_post_head;
                    state_d      = ST_RD_OK;
                end else begin
                    rdata_d      = '1;
                    state_d      = ST_RD_EMPTY;
                end
            end else if (wr) begin
                state_d = ST_WR_IGNORED;
            end else begin
                rdata_d = '0;
                state_d = ST_RD_UNMAPPED;
            end
        end
    end

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // Registered data path: read data and sticky overflow
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rdata    <= '0;
            overflow <= 1'b0;
        end else begin
            rdata <= rdata_d;
            if (state_d == ST_WR_DROP) begin
                overflow <= 1'b1;
            end
        end
    end

    // Outputs decoded from the state
    always_comb begin
        unique case (state_q)
            ST_RD_OK, ST_RD_EMPTY, ST_RD_UNMAPPED: rvalid = 1'b1;
            ST_IDLE, ST_WR_OK, ST_WR_DROP, ST_WR_IGNORED: rvalid = 1'b0;
            default: rvalid = 1'b0;
        endcase
    end

    // R2: every read strobe is answered on the next cycle
    p_read_latency_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (sel && !wr) |=> rvalid);

    // R6: an empty source queue yields all ones
    p_empty_read_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (sel && !wr && hit_in && in_free_empty) |=> (rvalid && rdata == '1));

    // R7: overflow never falls outside reset
    p_sticky_ovf_r7: assert property (@(posedge clk) disable iff (!rst_n)
        overflow |=> overflow);

    // R10: strobes to other offsets move no queue
    p_unmapped_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (sel && !hit_in && !hit_out) |->
            !(in_free_pop || in_post_push || out_post_pop || out_free_push));

endmodule

// File: rtl/mfq_port.sv
module mfq_port
    import mfq_pkg::*;
#(
    parameter int            DATA_W  = 32,
    parameter int            ADDR_W  = 12,
    parameter int            DEPTH   = 16,
    parameter logic [ADDR_W-1:0] IN_OFS  = 12'h040,
    parameter logic [ADDR_W-1:0] OUT_OFS = 12'h044
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              host_sel,
    input  logic              host_wr,
    input  logic [ADDR_W-1:0] host_addr,
    input  logic [DATA_W-1:0] host_wdata,
    output logic [DATA_W-1:0] host_rdata,
    output logic              host_rvalid,
    input  logic              lf_push_valid,
    input  logic [DATA_W-1:0] lf_push_data,
    output logic              lf_push_ready,
    input  logic              op_push_valid,
    input  logic [DATA_W-1:0] op_push_data,
    output logic              op_push_ready,
    output logic              ip_pop_valid,
    output logic [DATA_W-1:0] ip_pop_data,
    input  logic              ip_pop_ready,
    output logic              of_pop_valid,
    output logic [DATA_W-1:0] of_pop_data,
    input  logic              of_pop_ready,
    output logic [NUM_Q-1:0]  q_empty,
    output logic [NUM_Q-1:0]  q_full,
    output logic              overflow,
    output logic              post_irq
);
    logic [NUM_Q-1:0]             q_push;
    logic [NUM_Q-1:0]             q_pop;
    logic [NUM_Q-1:0][DATA_W-1:0] q_wdata;
    logic [NUM_Q-1:0][DATA_W-1:0] q_head;

    logic h_in_free_pop;
    logic h_in_post_push;
    logic h_out_post_pop;
    logic h_out_free_push;

    mfq_host_ctl #(
        .DW      (DATA_W),
        .AW      (ADDR_W),
        .IN_OFS  (IN_OFS),
        .OUT_OFS (OUT_OFS)
    ) u_host (
        .clk            (clk),
        .rst_n          (rst_n),
        .sel            (host_sel),
        .wr             (host_wr),
        .addr           (host_addr),
        .in_free_empty  (q_empty[QI_IN_FREE]),
        .in_free_head   (q_head[QI_IN_FREE]),
        .in_post_full   (q_full[QI_IN_POST]),
        .out_post_empty (q_empty[QI_OUT_POST]),
        .out_post_head  (q_head[QI_OUT_POST]),
        .out_free_full  (q_full[QI_OUT_FREE]),
        .in_free_pop    (h_in_free_pop),
        .in_post_push   (h_in_post_push),
        .out_post_pop   (h_out_post_pop),
        .out_free_push  (h_out_free_push),
        .rdata          (host_rdata),
        .rvalid         (host_rvalid),
        .overflow       (overflow)
    );

    // Queue steering: the host pops what the local side pushes, and vice versa
    assign q_push[QI_IN_FREE]   = lf_push_valid && !q_full[QI_IN_FREE];
    assign q_pop [QI_IN_FREE]   = h_in_free_pop;
    assign q_wdata[QI_IN_FREE]  = lf_push_data;

    assign q_push[QI_IN_POST]   = h_in_post_push;
    assign q_pop [QI_IN_POST]   = ip_pop_ready && !q_empty[QI_IN_POST];
    assign q_wdata[QI_IN_POST]  = host_wdata;

    assign q_push[QI_OUT_POST]  = op_push_valid && !q_full[QI_OUT_POST];
    assign q_pop [QI_OUT_POST]  = h_out_post_pop;
    assign q_wdata[QI_OUT_POST] = op_push_data;

    assign q_push[QI_OUT_FREE]  = h_out_free_push;
    assign q_pop [QI_OUT_FREE]  = of_pop_ready && !q_empty[QI_OUT_FREE];
    assign q_wdata[QI_OUT_FREE] = host_wdata;

    for (genvar gi = 0; gi < NUM_Q; gi++) begin : g_ring
        mfq_ring #(
            .DW    (DATA_W),
            .DEPTH (DEPTH)
        ) u_ring (
            .clk       (clk),
            .rst_n     (rst_n),
            .push      (q_push[gi]),
            .push_data (q_wdata[gi]),
            .pop       (q_pop[gi]),
            .head_data (q_head[gi]),
            .empty     (q_empty[gi]),
            .full      (q_full[gi])
        );
    end

    assign lf_push_ready = !q_full[QI_IN_FREE];
    assign op_push_ready = !q_full[QI_OUT_POST];
    assign ip_pop_valid  = !q_empty[QI_IN_POST];
    assign ip_pop_data   = q_head[QI_IN_POST];
    assign of_pop_valid  = !q_empty[QI_OUT_FREE];
    assign of_pop_data   = q_head[QI_OUT_FREE];
    assign post_irq      = !q_empty[QI_IN_POST];

    // R11: a host push and a local pop of the inbound posted queue in one
    // cycle leave it non-empty
    p_same_cycle_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (h_in_post_push && q_pop[QI_IN_POST]) |=> !q_empty[QI_IN_POST]);

endmodule

// File: tb/tb_mfq_port.sv
module tb_mfq_port;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        host_sel = 1'b0;
    logic        host_wr = 1'b0;
    logic [11:0] host_addr = '0;
    logic [31:0] host_wdata = '0;
    logic [31:0] host_rdata;
    logic        host_rvalid;
    logic        lf_push_valid = 1'b0;
    logic [31:0] lf_push_data = '0;
    logic        lf_push_ready;
    logic        op_push_valid = 1'b0;
    logic [31:0] op_push_data = '0;
    logic        op_push_ready;
    logic        ip_pop_valid;
    logic [31:0] ip_pop_data;
    logic        ip_pop_ready = 1'b0;
    logic        of_pop_valid;
    logic [31:0] of_pop_data;
    logic        of_pop_ready = 1'b0;
    logic [3:0]  q_empty;
    logic [3:0]  q_full;
    logic        overflow;
    logic        post_irq;

    int checks = 0;
    int errors = 0;

    localparam logic [11:0] A_IN  = 12'h040;
    localparam logic [11:0] A_OUT = 12'h044;

    always #5 clk = ~clk;

    mfq_port dut (.*);

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic host_write(input logic [11:0] a, input logic [31:0] d);
        @(negedge clk);
        host_sel = 1'b1; host_wr = 1'b1; host_addr = a; host_wdata = d;
        @(negedge clk);
        host_sel = 1'b0; host_wr = 1'b0;
    endtask

    task automatic host_read(input logic [11:0] a, output logic [31:0] d, output logic v);
        @(negedge clk);
        host_sel = 1'b1; host_wr = 1'b0; host_addr = a;
        @(negedge clk);
        host_sel = 1'b0;
        d = host_rdata; v = host_rvalid;
    endtask

    task automatic lf_push(input logic [31:0] d);
        @(negedge clk);
        lf_push_valid = 1'b1; lf_push_data = d;
        @(negedge clk);
        lf_push_valid = 1'b0;
    endtask

    task automatic op_push(input logic [31:0] d);
        @(negedge clk);
        op_push_valid = 1'b1; op_push_data = d;
        @(negedge clk);
        op_push_valid = 1'b0;
    endtask

    task automatic ip_pop(output logic [31:0] d, output logic v);
        @(negedge clk);
        d = ip_pop_data; v = ip_pop_valid;
        ip_pop_ready = 1'b1;
        @(negedge clk);
        ip_pop_ready = 1'b0;
    endtask

    task automatic of_pop(output logic [31:0] d, output logic v);
        @(negedge clk);
        d = of_pop_data; v = of_pop_valid;
        of_pop_ready = 1'b1;
        @(negedge clk);
        of_pop_ready = 1'b0;
    endtask

    task automatic t_reset();
        chk("R1 rdata", host_rdata, 32'h0);
        chk("R1 rvalid", {31'b0, host_rvalid}, 32'h0);
        chk("R1 empty", {28'b0, q_empty}, 32'hF);
        chk("R1 full", {28'b0, q_full}, 32'h0);
        chk("R1 overflow", {31'b0, overflow}, 32'h0);
        chk("R1 irq", {31'b0, post_irq}, 32'h0);
    endtask

    task automatic t_inbound_free();
        logic [31:0] d; logic v;
        lf_push(32'h0000_1100);
        lf_push(32'h0000_2200);
        lf_push(32'h0000_3300);
        host_read(A_IN, d, v);
        chk("R2 first pop", d, 32'h0000_1100);
        chk("R2 rvalid", {31'b0, v}, 32'h1);
        host_read(A_IN, d, v);
        chk("R2 second pop", d, 32'h0000_2200);
        host_read(A_IN, d, v);
        chk("R2 third pop", d, 32'h0000_3300);
        host_read(A_IN, d, v);
        chk("R6 empty read data", d, 32'hFFFF_FFFF);
        chk("R6 empty read valid", {31'b0, v}, 32'h1);
        chk("R6 queue still empty", {31'b0, q_empty[0]}, 32'h1);
        lf_push(32'h0000_4400);
        host_read(A_IN, d, v);
        chk("R6 queue untouched by empty read", d, 32'h0000_4400);
    endtask

    task automatic t_inbound_post();
        logic [31:0] d; logic v;
        chk("R9 irq low", {31'b0, post_irq}, 32'h0);
        host_write(A_IN, 32'hCAFE_0001);
        chk("R9 irq high", {31'b0, post_irq}, 32'h1);
        host_write(A_IN, 32'hCAFE_0002);
        chk("R3 free queue unaffected", {31'b0, q_empty[0]}, 32'h1);
        ip_pop(d, v);
        chk("R3 first local pop", d, 32'hCAFE_0001);
        chk("R3 valid", {31'b0, v}, 32'h1);
        ip_pop(d, v);
        chk("R3 second local pop", d, 32'hCAFE_0002);
        chk("R9 irq low after drain", {31'b0, post_irq}, 32'h0);
    endtask

    task automatic t_outbound();
        logic [31:0] d; logic v;
        op_push(32'hBEEF_0010);
        op_push(32'hBEEF_0020);
        host_read(A_OUT, d, v);
        chk("R4 first pop", d, 32'hBEEF_0010);
        host_read(A_OUT, d, v);
        chk("R4 second pop", d, 32'hBEEF_0020);
        host_write(A_OUT, 32'h0F0F_0001);
        chk("R5 posted queue empty", {31'b0, q_empty[2]}, 32'h1);
        of_pop(d, v);
        chk("R5 local pop", d, 32'h0F0F_0001);
        chk("R5 valid", {31'b0, v}, 32'h1);
    endtask

    task automatic t_full();
        logic [31:0] d; logic v;
        for (int i = 0; i < 16; i++) host_write(A_OUT, 32'h0000_A000 + i);
        chk("R8 out free full", {31'b0, q_full[3]}, 32'h1);
        chk("R7 no overflow yet", {31'b0, overflow}, 32'h0);
        host_write(A_OUT, 32'hDEAD_DEAD);
        chk("R7 overflow set", {31'b0, overflow}, 32'h1);
        for (int i = 0; i < 16; i++) begin
            of_pop(d, v);
            chk("R7 drain order", d, 32'h0000_A000 + i);
        end
        chk("R7 dropped write absent", {31'b0, q_empty[3]}, 32'h1);
        chk("R7 overflow sticky", {31'b0, overflow}, 32'h1);
        for (int i = 0; i < 16; i++) lf_push(32'h0000_B000 + i);
        chk("R8 local push ready low", {31'b0, lf_push_ready}, 32'h0);
        lf_push(32'h1234_5678);
        for (int i = 0; i < 16; i++) begin
            host_read(A_IN, d, v);
            chk("R8 free queue order", d, 32'h0000_B000 + i);
        end
        chk("R8 refused local push absent", {31'b0, q_empty[0]}, 32'h1);
    endtask

    task automatic t_unmapped();
        logic [31:0] d; logic v;
        host_write(12'h048, 32'h5555_AAAA);
        chk("R10 write ignored", {28'b0, q_empty}, 32'hF);
        host_read(12'h048, d, v);
        chk("R10 read data", d, 32'h0);
        chk("R10 read valid", {31'b0, v}, 32'h1);
        chk("R10 read moved nothing", {28'b0, q_empty}, 32'hF);
    endtask

    task automatic t_same_cycle();
        logic [31:0] d; logic v;
        host_write(A_IN, 32'h0000_00A1);
        @(negedge clk);
        host_sel = 1'b1; host_wr = 1'b1; host_addr = A_IN; host_wdata = 32'h0000_00B2;
        ip_pop_ready = 1'b1;
        chk("R11 head before", ip_pop_data, 32'h0000_00A1);
        @(negedge clk);
        host_sel = 1'b0; host_wr = 1'b0; ip_pop_ready = 1'b0;
        chk("R11 still valid", {31'b0, ip_pop_valid}, 32'h1);
        ip_pop(d, v);
        chk("R11 pushed entry kept", d, 32'h0000_00B2);
        chk("R11 queue empty", {31'b0, q_empty[1]}, 32'h1);
    endtask

    initial begin
        repeat (50000) @(posedge clk);
        errors++; checks++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_inbound_free();
        t_inbound_post();
        t_outbound();
        t_unmapped();
        t_same_cycle();
        t_full();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule